// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Mark Wakeup

This block turns an asynchronous serial line into received words. It runs from an oversampling tick at sixteen times the bit rate. It finds a falling edge and confirms the start bit at mid-bit, which rejects short glitches. It then samples every data bit and the stop bit at the centre of its period. A configuration bit picks the frame: 8 data bits or 9 data bits, sent least significant bit first, with one stop bit.

When parity is enabled, the parity bit sits in the top data position, so the payload is one bit shorter than the frame. A received word is delivered whole, parity bit included. The parity check counts the ones across every data bit of the frame. A failed check sets a sticky error flag, and that flag drives the interrupt only when the parity interrupt is enabled. A low stop bit sets a framing flag, and the word is still delivered.

A mute request puts the receiver to sleep. While muted, it discards every word whose top data bit is 0. The first word whose top data bit is 1 is an address word: it ends mute and is delivered like any other word. A read-acknowledge pulse clears the data-ready flag and both error flags.

Top module: `addr_wake_rx`

## Requirements
- R1: After reset, `rdrf`, `par_err`, `frm_err`, `irq` and `muted` are 0 and `rx_data` is 0.
- R2: With `cfg_nine`=0, a frame of start bit (0), 8 data bits sent LSB first and a stop bit appears on `rx_data[7:0]` with `rx_data[8]`=0, and `rdrf` is set.
- R3: With `cfg_nine`=1, all 9 data bits appear on `rx_data[8:0]`, LSB first on the line.
- R4: With `cfg_par_en`=1 and `cfg_par_odd`=0, `par_err` is set when the data bits of the frame, top (parity) bit included, hold an odd number of ones.
- R5: With `cfg_par_en`=1 and `cfg_par_odd`=1, `par_err` is set when that count is even.
- R6: With `cfg_par_en`=0, a received word never sets `par_err`.
- R7: `irq` is 1 exactly when `par_err` is 1 and `cfg_par_ie` is 1.
- R8: A stop bit sampled as 0 sets `frm_err`, and the word is still delivered with `rdrf` set.
- R9: While `muted`=1, a word whose top data bit (bit 7 when `cfg_nine`=0, bit 8 when `cfg_nine`=1) is 0 changes none of `rx_data`, `rdrf`, `par_err` or `frm_err`.
- R10: While muted, a word whose top data bit is 1 clears `muted` and is delivered as a normal word. This test reads the raw top bit even when parity is enabled.
- R11: The flags `rdrf`, `par_err` and `frm_err` stay set until a one-cycle `rd_ack` pulse clears them.
- R12: A low pulse on `rxd` shorter than half a bit period does not start a frame.
- R13: A one-cycle `mute_req` pulse sets `muted` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_par_ie | input | 1 | Parity interrupt enable |
| mute_req | input | 1 | Pulse to enter mute mode |
| rd_ack | input | 1 | Pulse to clear data-ready and error flags |
| rx_data | output | 9 | Last delivered word |
| rdrf | output | 1 | Received data ready |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| irq | output | 1 | Parity interrupt |
| muted | output | 1 | Receiver is in mute mode |

## Verification
The bench sweeps all 256 words in the 8-bit frame under even parity, and a spread of 9-bit words under odd parity and with parity off. A swapped parity sense, a wrong bit order or the wrong frame length shows up as a data or flag miscompare. Mute tests send non-address words that carry bad parity and a low stop bit. A design that filtered too late would then raise flags or change data. They also send address words whose parity bit is the mark, so a design that tested parity instead of the raw top bit would stay asleep. Further cases cover a glitch shorter than half a bit, flags that must survive a second good word until acknowledged, and a slower tick rate.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int unsigned WORD_W = 9;
    localparam int unsigned OVS    = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        word_t bits;
        logic  stop_ok;
    } frame_t;

    function automatic logic frame_msb(input word_t w, input logic nine);
        return nine ? w[WORD_W-1] : w[WORD_W-2];
    endfunction

    function automatic logic parity_bad(input word_t w, input logic odd);
        return (^w) ^ odd;
    endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
    import arx_pkg::*;
#(
    parameter int unsigned OVS_N = OVS
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   line,
    input  logic   nine,
    output logic   fr_valid,
    output frame_t fr
);
    localparam int unsigned CNT_W = $clog2(OVS_N);
    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS_N/2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS_N - 1);
    localparam logic [IDX_W-1:0] IDX_NINE = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] IDX_EIGHT = IDX_W'(WORD_W - 2);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    word_t            shreg_q;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = nine ? IDX_NINE : IDX_EIGHT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            idx_q    <= '0;
            shreg_q  <= '0;
            fr_valid <= 1'b0;
            fr       <= '0;
        end else begin
            fr_valid <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!line) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == CNT_HALF) begin
                            cnt_q <= '0;
                            if (!line) begin
                                state_q <= ST_DATA;
                                idx_q   <= '0;
                                shreg_q <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q          <= '0;
                            shreg_q[idx_q] <= line;
                            if (idx_q == last_idx) state_q <= ST_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q      <= '0;
                            fr_valid   <= 1'b1;
                            fr.bits    <= shreg_q;
                            fr.stop_ok <= line;
                            state_q    <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/arx_status.sv
module arx_status
    import arx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fr_valid,
    input  frame_t fr,
    input  logic   fr_msb,
    input  logic   par_en,
    input  logic   par_odd,
    input  logic   par_ie,
    input  logic   mute_req,
    input  logic   rd_ack,
    output word_t  data_q,
    output logic   rdrf_q,
    output logic   pe_q,
    output logic   fe_q,
    output logic   muted_q,
    output logic   irq
);
    logic accept;
    logic bad_par;

    assign accept  = fr_valid && (!muted_q || fr_msb);
    assign bad_par = par_en && parity_bad(fr.bits, par_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            rdrf_q  <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            muted_q <= 1'b0;
        end else begin
            if (rd_ack) begin
                rdrf_q <= 1'b0;
                pe_q   <= 1'b0;
                fe_q   <= 1'b0;
            end
            if (accept) begin
                data_q <= fr.bits;
                rdrf_q <= 1'b1;
                if (bad_par)     pe_q <= 1'b1;
                if (!fr.stop_ok) fe_q <= 1'b1;
            end
            if (mute_req)                         muted_q <= 1'b1;
            else if (muted_q && fr_valid && fr_msb) muted_q <= 1'b0;
        end
    end

    assign irq = pe_q & par_ie;
endmodule

// File: rtl/addr_wake_rx.sv
module addr_wake_rx
    import arx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_par_ie,
    input  logic              mute_req,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rx_data,
    output logic              rdrf,
    output logic              par_err,
    output logic              frm_err,
    output logic              irq,
    output logic              muted
);
    logic   line_s;
    logic   fr_valid;
    frame_t fr;
    logic   fr_msb;

    arx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    arx_deframer #(.OVS_N(OVS)) u_deframer (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .line     (line_s),
        .nine     (cfg_nine),
        .fr_valid (fr_valid),
        .fr       (fr)
    );

    assign fr_msb = frame_msb(fr.bits, cfg_nine);

    arx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .fr_valid (fr_valid),
        .fr       (fr),
        .fr_msb   (fr_msb),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .par_ie   (cfg_par_ie),
        .mute_req (mute_req),
        .rd_ack   (rd_ack),
        .data_q   (rx_data),
        .rdrf_q   (rdrf),
        .pe_q     (par_err),
        .fe_q     (frm_err),
        .muted_q  (muted),
        .irq      (irq)
    );
endmodule

// File: rtl/arx_checker.sv
module arx_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_par_en,
    input logic       cfg_par_ie,
    input logic       mute_req,
    input logic       rd_ack,
    input logic [8:0] rx_data,
    input logic       rdrf,
    input logic       par_err,
    input logic       frm_err,
    input logic       irq,
    input logic       muted,
    input logic       fr_valid,
    input logic       fr_msb
);
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !fr_valid |=> $stable(rx_data));

    p_no_parity_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_par_en && !par_err |=> !par_err);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg_par_ie |-> !irq);

    p_ignore_muted_r9: assert property (@(posedge clk) disable iff (rst)
        muted && fr_valid && !fr_msb && !rd_ack |=>
            $stable(rx_data) && $stable(rdrf) && $stable(par_err) && $stable(frm_err));

    p_wake_r10: assert property (@(posedge clk) disable iff (rst)
        muted && fr_valid && fr_msb && !mute_req |=> !muted && rdrf);

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
        rd_ack && !fr_valid |=> !rdrf && !par_err && !frm_err);

    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        par_err && !rd_ack |=> par_err);

    p_mute_set_r13: assert property (@(posedge clk) disable iff (rst)
        mute_req |=> muted);
endmodule

bind addr_wake_rx arx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_par_en (cfg_par_en),
    .cfg_par_ie (cfg_par_ie),
    .mute_req   (mute_req),
    .rd_ack     (rd_ack),
    .rx_data    (rx_data),
    .rdrf       (rdrf),
    .par_err    (par_err),
    .frm_err    (frm_err),
    .irq        (irq),
    .muted      (muted),
    .fr_valid   (fr_valid),
    .fr_msb     (fr_msb)
);

// File: tb/tb_addr_wake_rx.sv
module tb_addr_wake_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b0;
    logic       cfg_nine = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_par_ie = 1'b0;
    logic       mute_req = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       rdrf, par_err, frm_err, irq, muted;

    int n_vec = 0;
    int n_bad = 0;
    int tick_div = 1;
    bit done = 1'b0;

    logic [8:0] m_data = '0;
    logic       m_rdrf = 1'b0, m_pe = 1'b0, m_fe = 1'b0, m_muted = 1'b0;

    always #10 clk = ~clk;

    addr_wake_rx dut (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_par_ie(cfg_par_ie), .mute_req(mute_req), .rd_ack(rd_ack),
        .rx_data(rx_data), .rdrf(rdrf), .par_err(par_err), .frm_err(frm_err),
        .irq(irq), .muted(muted)
    );

    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = tcnt + 1;
            if (tcnt >= tick_div) begin
                baud_tick = 1'b1;
                tcnt = 0;
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold_bit();
        repeat (16 * tick_div) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        chk({req, " data"},  int'(rx_data), int'(m_data));
        chk({req, " rdrf"},  int'(rdrf),    int'(m_rdrf));
        chk({req, " perr"},  int'(par_err), int'(m_pe));
        chk({req, " ferr"},  int'(frm_err), int'(m_fe));
        chk({req, " irq R7"}, int'(irq),    int'(m_pe & cfg_par_ie));
        chk({req, " muted"}, int'(muted),   int'(m_muted));
    endtask

    task automatic send(input logic [8:0] w, input logic stop_v, input string req);
        logic [8:0] wm;
        logic msb;
        int nb;
        nb  = cfg_nine ? 9 : 8;
        wm  = cfg_nine ? w : {1'b0, w[7:0]};
        msb = cfg_nine ? w[8] : w[7];
        rxd = 1'b0;
        hold_bit();
        for (int i = 0; i < nb; i++) begin
            rxd = w[i];
            hold_bit();
        end
        rxd = stop_v;
        hold_bit();
        rxd = 1'b1;
        repeat (3) hold_bit();
        if (!(m_muted && !msb)) begin
            m_muted = 1'b0;
            m_data  = wm;
            m_rdrf  = 1'b1;
            if (cfg_par_en && (($countones(wm) % 2) != int'(cfg_par_odd))) m_pe = 1'b1;
            if (!stop_v) m_fe = 1'b1;
        end
        check_all(req);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        m_rdrf = 1'b0;
        m_pe   = 1'b0;
        m_fe   = 1'b0;
        chk("R11 ack rdrf", int'(rdrf), 0);
        chk("R11 ack perr", int'(par_err), 0);
        chk("R11 ack ferr", int'(frm_err), 0);
    endtask

    task automatic go_mute();
        @(negedge clk) mute_req = 1'b1;
        @(negedge clk) mute_req = 1'b0;
        m_muted = 1'b1;
        chk("R13 mute set", int'(muted), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R2 R4 R7: every 8-bit word, even parity, interrupt on
        cfg_nine = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_par_ie = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 1'b1, "R2/R4");
            ack();
        end

        // R3 R5: 9-bit words, odd parity, interrupt off
        cfg_nine = 1'b1; cfg_par_odd = 1'b1; cfg_par_ie = 1'b0;
        for (int v = 0; v < 512; v += 7) begin
            send(9'(v), 1'b1, "R3/R5");
            ack();
        end

        // R6: parity off
        cfg_par_en = 1'b0;
        for (int v = 1; v < 512; v += 37) begin
            send(9'(v), 1'b1, "R6");
            ack();
        end

        // R8: low stop bit
        cfg_nine = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_par_ie = 1'b1;
        send(9'h05A, 1'b0, "R8 frame err");
        ack();

        // R11: flags persist across a clean word until acknowledged
        send(9'h001, 1'b0, "R11 first");
        send(9'h003, 1'b1, "R11 sticky");
        ack();

        // R9 R10: mute, 8-bit, ignored word has bad parity and low stop bit
        go_mute();
        send(9'h001, 1'b0, "R9 ignored");
        send(9'h07F, 1'b1, "R9 ignored2");
        send(9'h081, 1'b1, "R10 wake8");
        ack();

        // R10 with 9-bit odd parity: raw top bit is the mark
        cfg_nine = 1'b1; cfg_par_odd = 1'b1;
        go_mute();
        send(9'h0FF, 1'b1, "R9 ignored9");
        send(9'h100, 1'b1, "R10 wake9");
        ack();
        send(9'h023, 1'b1, "R10 awake");
        ack();

        // R12: short glitch
        cfg_nine = 1'b0; cfg_par_en = 1'b0;
        @(negedge clk) rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (3) hold_bit();
        check_all("R12 glitch");
        send(9'h0C3, 1'b1, "R12 after glitch");
        ack();

        // slower tick
        tick_div = 3;
        send(9'h0A5, 1'b1, "R2 slow tick");
        ack();

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule